// File: doc/BRIEF.md
# Packed Masked Lane Writeback Unit

This block applies a per-lane scalar operation to a packed vector of 16-bit elements and writes the result into a destination vector under the control of a per-lane mask. A lane whose mask bit is clear is either zeroed or left with its previous destination value, depending on a zeroing flag. A global flag can disable masking, and another can broadcast lane 0 of the source into every lane. A 2-bit length select sets how many lanes are active at run time. Every destination bit above the active length is cleared.

The scalar lane operation is a small parameterised stub. It can pass the value through, negate it (flip bit 15) or take its absolute value (clear bit 15). The default is negation. The source lanes, the previous destination, the mask and all control flags are registered together in a first stage. The merge result is registered in a second stage. A single valid/ready handshake covers the whole vector at each end, so each writeback always uses its own operands.

Top module: `vec_mask_wb`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: `vlen_sel` sets the active lane count: code 0 gives 8 lanes (128 bits), code 1 gives 16 lanes (256 bits), and codes 2 and 3 give 32 lanes (512 bits). Lane i occupies bits [16i+15:16i].
- R3: An active lane i is computed when `mask_off` is 1 or `lane_mask[i]` is 1.
- R4: When `bcast` is 1, every computed lane takes its operand from source lane 0 (`src_vec[15:0]`).
- R5: An active lane that is not computed is written with 0 when `zero_mode` is 1.
- R6: An active lane that is not computed keeps its `old_vec` value when `zero_mode` is 0.
- R7: Every destination lane at or above the active lane count is 0, whatever the mask, the flags and `old_vec` hold. Mask bits beyond the active count have no effect.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `dst_vec` is held stable.
- R9: The unit holds at most two vectors. When the output is stalled and the first stage is full, `in_ready` is 0.
- R10: Results leave in the order they were accepted, each one computed only from the operands that were accepted with it.
- R11: With the default lane operation, a computed lane's result is the operand with bit 15 inverted and bits 14:0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input vector and controls are valid |
| in_ready | output | 1 | Unit accepts an input this cycle |
| src_vec | input | MAX_W | Packed source lanes |
| old_vec | input | MAX_W | Previous destination contents |
| lane_mask | input | 32 | Per-lane write enable, bit i for lane i |
| mask_off | input | 1 | Compute every active lane, ignoring the mask |
| zero_mode | input | 1 | Unselected lanes are zeroed instead of kept |
| bcast | input | 1 | Lane 0 of the source feeds all lanes |
| vlen_sel | input | 2 | Active length code |
| out_valid | output | 1 | Destination vector is valid |
| out_ready | input | 1 | Downstream takes the destination this cycle |
| dst_vec | output | MAX_W | Full-width destination vector |

## Verification
On every cycle, the assertions check the following:
- Each lane falls into exactly one class: computed, zeroed, kept or tail.
- Zeroing mode never keeps an old lane.
- Unmasked operation leaves no active lane uncomputed.
- Broadcast yields identical staged results.
- The tail above the active length is zero.
- Stalled output holds steady.
- A full, stalled unit refuses input.

Only the bench scenarios can show that the values are right. These scenarios sweep every length code, flag combination and several mask patterns, including mask bits above the active length, against an arithmetic model. They also show that results keep their order and their own operands when the output stalls at random.

// File: rtl/hw_lanes_pkg.sv
package hw_lanes_pkg;

  localparam int LANE_W   = 16;
  localparam int MASK_W   = 32;

  localparam int OP_PASS  = 0;
  localparam int OP_NEG   = 1;
  localparam int OP_ABS   = 2;

  typedef logic [LANE_W-1:0] lane_t;

  typedef struct packed {
    logic       mask_off;
    logic       zero_mode;
    logic       bcast;
    logic [1:0] vlen;
  } wb_ctrl_t;

  // Lanes enabled by a length code; codes 2 and 3 both mean the full 512 bits.
  function automatic int lanes_for(logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 16;
      default: return 32;
    endcase
  endfunction

  // Bit position where the cleared tail starts for a length code.
  function automatic int tail_bit(logic [1:0] code);
    return lanes_for(code) * LANE_W;
  endfunction

endpackage

// File: rtl/lane_fn.sv
module lane_fn
  import hw_lanes_pkg::*;
#(
  parameter int OP = OP_NEG
) (
  input  lane_t a,
  output lane_t y
);

  generate
    if (OP == OP_PASS) begin : g_pass
      assign y = a;
    end else if (OP == OP_ABS) begin : g_abs
      assign y = {1'b0, a[LANE_W-2:0]};
    end else begin : g_neg
      assign y = {~a[LANE_W-1], a[LANE_W-2:0]};
    end
  endgenerate

endmodule

// File: rtl/lane_front.sv
module lane_front
  import hw_lanes_pkg::*;
#(
  parameter int LANES   = 32,
  parameter int LANE_OP = OP_NEG,
  localparam int VW     = LANES * LANE_W
) (
  input  logic [VW-1:0] src_vec,
  input  logic          bcast,
  output logic [VW-1:0] res_vec
);

  lane_t lane0;
  assign lane0 = src_vec[LANE_W-1:0];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    lane_t opnd;
    lane_t rslt;

    assign opnd = bcast ? lane0 : src_vec[i*LANE_W +: LANE_W];

    lane_fn #(.OP(LANE_OP)) u_fn (
      .a (opnd),
      .y (rslt)
    );

    assign res_vec[i*LANE_W +: LANE_W] = rslt;
  end

endmodule

// File: rtl/lane_merge.sv
module lane_merge
  import hw_lanes_pkg::*;
#(
  parameter int LANES = 32,
  localparam int VW   = LANES * LANE_W
) (
  input  logic [VW-1:0]    res_vec,
  input  logic [VW-1:0]    old_vec,
  input  logic [LANES-1:0] mask,
  input  wb_ctrl_t         ctrl,
  output logic [VW-1:0]    dst,
  output logic [LANES-1:0] calc_l,
  output logic [LANES-1:0] zero_l,
  output logic [LANES-1:0] keep_l,
  output logic [LANES-1:0] tail_l
);

  function automatic logic [LANES-1:0] span(logic [1:0] code);
    logic [LANES-1:0] s;
    for (int k = 0; k < LANES; k++) s[k] = (k < lanes_for(code));
    return s;
  endfunction

  logic [LANES-1:0] act_l;
  assign act_l = span(ctrl.vlen);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic pick;
    assign pick      = ctrl.mask_off | mask[i];
    assign calc_l[i] = act_l[i] & pick;
    assign zero_l[i] = act_l[i] & ~pick & ctrl.zero_mode;
    assign keep_l[i] = act_l[i] & ~pick & ~ctrl.zero_mode;
    assign tail_l[i] = ~act_l[i];

    assign dst[i*LANE_W +: LANE_W] =
      calc_l[i] ? res_vec[i*LANE_W +: LANE_W] :
      keep_l[i] ? old_vec[i*LANE_W +: LANE_W] : '0;
  end

endmodule

// File: rtl/vec_mask_wb.sv
module vec_mask_wb
  import hw_lanes_pkg::*;
#(
  parameter int MAX_W   = 512,
  parameter int LANE_OP = OP_NEG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [MAX_W-1:0] src_vec,
  input  logic [MAX_W-1:0] old_vec,
  input  logic [31:0]      lane_mask,
  input  logic             mask_off,
  input  logic             zero_mode,
  input  logic             bcast,
  input  logic [1:0]       vlen_sel,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [MAX_W-1:0] dst_vec
);

  localparam int LANES = MAX_W / LANE_W;

  // Handshake events, named for the checker.
  logic acc;
  logic s1_move;
  logic s2_ready;
  logic out_fire;

  logic             s1_valid;
  logic [MAX_W-1:0] s1_res;
  logic [MAX_W-1:0] s1_old;
  logic [LANES-1:0] s1_mask;
  wb_ctrl_t         s1_ctrl;
  logic [1:0]       s2_vlen;

  logic [LANES-1:0] mask_in;
  logic [MAX_W-1:0] front_res;
  logic [MAX_W-1:0] merged;
  logic [LANES-1:0] calc_l, zero_l, keep_l, tail_l;
  wb_ctrl_t         ctrl_in;

  for (genvar i = 0; i < LANES; i++) begin : g_mask
    if (i < MASK_W) begin : g_have
      assign mask_in[i] = lane_mask[i];
    end else begin : g_none
      assign mask_in[i] = 1'b0;
    end
  end

  assign ctrl_in = '{mask_off: mask_off, zero_mode: zero_mode,
                     bcast: bcast, vlen: vlen_sel};

  assign out_fire = out_valid & out_ready;
  assign s2_ready = ~out_valid | out_ready;
  assign s1_move  = s1_valid & s2_ready;
  assign in_ready = ~s1_valid | s2_ready;
  assign acc      = in_valid & in_ready;

  lane_front #(.LANES(LANES), .LANE_OP(LANE_OP)) u_front (
    .src_vec (src_vec),
    .bcast   (bcast),
    .res_vec (front_res)
  );

  // Stage 1: lane results travel with their own mask, old value and flags.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
    end else if (acc) begin
      s1_valid <= 1'b1;
    end else if (s1_move) begin
      s1_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      s1_res  <= front_res;
      s1_old  <= old_vec;
      s1_mask <= mask_in;
      s1_ctrl <= ctrl_in;
    end
  end

  lane_merge #(.LANES(LANES)) u_merge (
    .res_vec (s1_res),
    .old_vec (s1_old),
    .mask    (s1_mask),
    .ctrl    (s1_ctrl),
    .dst     (merged),
    .calc_l  (calc_l),
    .zero_l  (zero_l),
    .keep_l  (keep_l),
    .tail_l  (tail_l)
  );

  // Stage 2: registered destination.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (s1_move) begin
      out_valid <= 1'b1;
    end else if (out_fire) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_move) begin
      dst_vec <= merged;
      s2_vlen <= s1_ctrl.vlen;
    end
  end

endmodule

// File: rtl/vec_mask_wb_chk.sv
module vec_mask_wb_chk
  import hw_lanes_pkg::*;
#(
  parameter int MAX_W  = 512,
  localparam int LANES = MAX_W / LANE_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [MAX_W-1:0] dst_vec,
  input logic             s1_valid,
  input wb_ctrl_t         s1_ctrl,
  input logic [MAX_W-1:0] s1_res,
  input logic [1:0]       s2_vlen,
  input logic [LANES-1:0] calc_l,
  input logic [LANES-1:0] zero_l,
  input logic [LANES-1:0] keep_l,
  input logic [LANES-1:0] tail_l
);

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && in_ready));

  assert_hold_when_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(dst_vec)));

  assert_full_refuses_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && s1_valid) |-> !in_ready);

  assert_tail_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((dst_vec >> tail_bit(s2_vlen)) == '0));

  assert_zero_never_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_ctrl.zero_mode) |-> (keep_l == '0));

  assert_nomask_all_calc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_ctrl.mask_off) |-> ((calc_l | tail_l) == '1));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assert_one_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |-> ($countones({calc_l[i], zero_l[i], keep_l[i], tail_l[i]}) == 1));

    assert_bcast_same_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_ctrl.bcast) |->
        (s1_res[i*LANE_W +: LANE_W] == s1_res[LANE_W-1:0]));
  end

endmodule

bind vec_mask_wb vec_mask_wb_chk #(.MAX_W(MAX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .dst_vec   (dst_vec),
  .s1_valid  (s1_valid),
  .s1_ctrl   (s1_ctrl),
  .s1_res    (s1_res),
  .s2_vlen   (s2_vlen),
  .calc_l    (calc_l),
  .zero_l    (zero_l),
  .keep_l    (keep_l),
  .tail_l    (tail_l)
);

// File: tb/vec_mask_wb_test.sv
module vec_mask_wb_test;

  localparam int W = 512;

  typedef struct {
    logic [W-1:0] src;
    logic [W-1:0] old;
    logic [31:0]  mask;
    logic         moff;
    logic         zero;
    logic         bc;
    logic [1:0]   vsel;
  } txn_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] src_vec = '0;
  logic [W-1:0] old_vec = '0;
  logic [31:0]  lane_mask = '0;
  logic         mask_off = 1'b0;
  logic         zero_mode = 1'b0;
  logic         bcast = 1'b0;
  logic [1:0]   vlen_sel = 2'd0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] dst_vec;

  int checks = 0;
  int fails  = 0;
  int ready_mode = 0;
  int cyc = 0;
  txn_t exp_q[$];

  always #2ns clk = ~clk;

  vec_mask_wb uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src_vec(src_vec), .old_vec(old_vec), .lane_mask(lane_mask),
    .mask_off(mask_off), .zero_mode(zero_mode), .bcast(bcast),
    .vlen_sel(vlen_sel), .out_valid(out_valid), .out_ready(out_ready),
    .dst_vec(dst_vec)
  );

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Model of one destination lane, written from the requirements.
  function automatic logic [15:0] model_lane(txn_t t, int i, output string tag);
    int n;
    logic [15:0] e;
    n = (t.vsel == 2'd0) ? 8 : (t.vsel == 2'd1) ? 16 : 32;
    if (i >= n) begin
      tag = "R2/R7";
      return 16'h0000;
    end
    if (t.moff || t.mask[i]) begin
      e = t.bc ? t.src[15:0] : t.src[16*i +: 16];
      tag = t.bc ? "R4/R11" : "R3/R11";
      return e ^ 16'h8000;
    end
    if (t.zero) begin
      tag = "R5";
      return 16'h0000;
    end
    tag = "R6";
    return t.old[16*i +: 16];
  endfunction

  function automatic logic [W-1:0] rand_vec();
    logic [W-1:0] v;
    for (int k = 0; k < W/32; k++) v[32*k +: 32] = $urandom() | 32'h0001_0001;
    return v;
  endfunction

  // Output readiness driver.
  always @(negedge clk) begin
    cyc++;
    case (ready_mode)
      0:       out_ready <= 1'b1;
      1:       out_ready <= ($urandom() % 3) != 0;
      default: out_ready <= 1'b0;
    endcase
  end

  // Monitor: sample 1 ns after the falling edge.
  logic [W-1:0] held_dst;
  bit           was_stalled = 0;
  always @(negedge clk) begin
    #1ns;
    if (rst_n) begin
      if (was_stalled) begin
        check(out_valid === 1'b1, "R8 valid held", {511'b0, out_valid}, 1);
        check(dst_vec === held_dst, "R8 data held", dst_vec, held_dst);
      end
      was_stalled = out_valid && !out_ready;
      held_dst = dst_vec;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R10 unexpected output", dst_vec, '0);
        end else begin
          txn_t t;
          logic [W-1:0] full;
          t = exp_q.pop_front();
          for (int i = 0; i < 32; i++) begin
            string tag;
            logic [15:0] e;
            e = model_lane(t, i, tag);
            full[16*i +: 16] = e;
            check(dst_vec[16*i +: 16] === e, $sformatf("%s lane %0d", tag, i),
                  W'(dst_vec[16*i +: 16]), W'(e));
          end
          check(dst_vec === full, "R10 vector order", dst_vec, full);
        end
      end
    end
  end

  task automatic send(txn_t t);
    @(negedge clk);
    src_vec = t.src; old_vec = t.old; lane_mask = t.mask;
    mask_off = t.moff; zero_mode = t.zero; bcast = t.bc; vlen_sel = t.vsel;
    in_valid = 1'b1;
    #1ns;
    while (!in_ready) begin
      @(negedge clk);
      #1ns;
    end
    exp_q.push_back(t);
    @(posedge clk);
  endtask

  task automatic idle_in();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  // Watchdog.
  initial begin
    #400us;
    fails++;
    checks++;
    $display("FAIL watchdog expired after %0d cycles", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    txn_t t;
    logic [31:0] pats[3];
    pats[0] = 32'hA5A5_5A5A;
    pats[1] = 32'hFFFF_0000;
    pats[2] = 32'h0000_00F3;

    repeat (3) @(negedge clk);
    #1ns;
    check(out_valid === 1'b0, "R1 out_valid after reset", {511'b0, out_valid}, 0);
    check(in_ready === 1'b1, "R1 in_ready after reset", {511'b0, in_ready}, 1);
    @(negedge clk);
    rst_n = 1'b1;

    // Full sweep of length codes, flags and mask patterns.
    for (int pass = 0; pass < 2; pass++) begin
      ready_mode = pass;
      for (int c = 0; c < 32; c++) begin
        for (int p = 0; p < 4; p++) begin
          t.src  = rand_vec();
          t.old  = rand_vec();
          t.mask = (p == 3) ? $urandom() : pats[p];
          t.vsel = c[1:0];
          t.moff = c[2];
          t.zero = c[3];
          t.bc   = c[4];
          send(t);
        end
      end
      idle_in();
      drain();
    end

    // Backpressure: fill both stages with the output stalled.
    ready_mode = 2;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      t.src = rand_vec(); t.old = rand_vec(); t.mask = $urandom();
      t.vsel = 2'd1; t.moff = 1'b0; t.zero = k[0]; t.bc = 1'b0;
      send(t);
    end
    idle_in();
    #1ns;
    check(in_ready === 1'b0, "R9 full and stalled refuses input", {511'b0, in_ready}, 0);
    check(out_valid === 1'b1, "R9 output pending", {511'b0, out_valid}, 1);
    repeat (4) @(negedge clk);
    #1ns;
    check(in_ready === 1'b0, "R9 still refusing", {511'b0, in_ready}, 0);
    ready_mode = 0;
    drain();
    check(exp_q.size() == 0, "R10 all results delivered", W'(exp_q.size()), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule